// File: doc/BRIEF.md
# SPI Command Front End for a Battery-Free Nonvolatile SRAM

This block is the serial slave side of a 32K x 8 static memory that keeps a nonvolatile shadow copy. A host talks to it over a four-wire SPI link in mode 0. Each selection starts with an 8-bit opcode. The block decodes ten opcodes. It keeps a status byte that holds both volatile and nonvolatile bits, and it guards every modifying command with a write-enable latch. It runs streaming reads and writes on the array with an address that steps up by one after each byte. It passes save, restore and automatic-save enable and disable requests on to a separate sequencer as one-cycle strobes.

All logic runs on one system clock `clk`. The SPI pins are assumed to be already synchronous to `clk`. The block finds SCK and CS_n edges by comparing each pin with its value one cycle earlier. The control state machine has these states:

- `ST_IDLE`: not selected.
- `ST_OPCODE`: receiving the opcode.
- `ST_ADDR_HI` and `ST_ADDR_LO`: receiving the two address bytes.
- `ST_RD_DATA` and `ST_WR_DATA`: streaming array data.
- `ST_RDSR`: returning the status byte.
- `ST_WRSR`: waiting for the new status byte.
- `ST_DONE`: a command has been accepted and any further bytes are ignored.
- `ST_IGNORE`: the command was refused and the rest of the selection is ignored.

The transitions are:

- `ST_IDLE` goes to `ST_OPCODE` on a CS_n falling edge.
- `ST_OPCODE` goes to `ST_RDSR`, `ST_WRSR`, `ST_ADDR_HI`, `ST_DONE` or `ST_IGNORE` on the eighth opcode bit, depending on the decode.
- `ST_ADDR_HI` goes to `ST_ADDR_LO`.
- `ST_ADDR_LO` goes to `ST_RD_DATA` for a read and to `ST_WR_DATA` for a write.
- `ST_WRSR` goes to `ST_DONE` after the data byte.
- Every state returns to `ST_IDLE` on a CS_n rising edge.

Top module: `spi_nvsram_cmd`

## Requirements
- R1: Opcodes, addresses and data move MSB first in 8-bit groups, in SPI mode 0. MOSI is taken on the rising SCK edge. MISO changes only after a falling SCK edge. The first bit of a returned byte is present before the first rising edge of that byte.
- R2: After reset the block counts as deselected even if CS_n is already low. SCK activity before the first CS_n falling edge has no effect, and MISO stays 0.
- R3: The opcode values are: 0x06 sets WEN, 0x04 clears WEN, 0x05 reads status, 0x01 writes status, 0x03 reads the array, 0x02 writes the array, 0x3C requests a save, 0x60 requests a restore, 0x59 enables automatic save and 0x19 disables automatic save.
- R4: Opcode 0x1E and every other value not listed in R3 is ignored. It does not change status, it produces no strobe or array write, and MISO stays 0 for the rest of the selection.
- R5: The status byte layout is: bit 7 WPEN, bits 6:4 always 0, bit 3 BP1, bit 2 BP0, bit 1 WEN, bit 0 = `seq_busy`. Reset clears WEN and loads {WPEN, BP1, BP0} from `nv_init[2:0]`, in that bit order.
- R6: An opcode whose eighth bit arrives while `recall_active` is high is discarded, along with the rest of that selection.
- R7: Array write, status write, save, automatic-save enable and automatic-save disable are refused while WEN is 0. When one of them is accepted, WEN clears at the CS_n rising edge that ends the selection.
- R8: Read and write take two address bytes. Bit 7 of the first byte is ignored, which leaves a 15-bit address. The address advances after every data byte and wraps from 0x7FFF to 0x0000. A read returns `mem_rdata` for the current address as each data byte.
- R9: BP1:BP0 select the protected range: 00 none, 01 0x6000 to 0x7FFF, 10 0x4000 to 0x7FFF, 11 the whole array. A write into the range is dropped, but the address still advances.
- R10: A status write loads WPEN from data bit 7 and BP1:BP0 from data bits 3:2. `nv_bits` shows {WPEN, BP1, BP0}. When WPEN is 1 and `wp_n` is low, the status write is refused and WEN is left set.
- R11: Save, restore, automatic-save enable and automatic-save disable each raise their own strobe for exactly one cycle when the opcode is decoded. Restore does not need WEN.
- R12: After the status-read opcode, every following byte of the selection returns the current status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, 0 when not selected |
| wp_n | input | 1 | Hardware write-protect, active low |
| seq_busy | input | 1 | Sequencer busy, shown in status bit 0 |
| recall_active | input | 1 | A restore is running; new opcodes are refused |
| nv_init | input | 3 | Saved {WPEN, BP1, BP0} loaded at reset |
| nv_bits | output | 3 | Current {WPEN, BP1, BP0} for the sequencer to save |
| mem_addr | output | ADDR_W | Array address |
| mem_wdata | output | 8 | Array write data |
| mem_we | output | 1 | Array write strobe, one cycle |
| mem_rdata | input | 8 | Array read data for `mem_addr` |
| store_req | output | 1 | Save request strobe |
| recall_req | output | 1 | Restore request strobe |
| as_en_req | output | 1 | Automatic-save enable strobe |
| as_dis_req | output | 1 | Automatic-save disable strobe |

## Verification
Strobes, array writes and WEN changes take effect in the `clk` cycle that registers the eighth rising SCK edge of a byte, or the CS_n rising edge. A returned byte bit appears on MISO one `clk` cycle after the falling SCK edge that precedes it. The bench drives each SCK half period for four system clocks and samples MISO three clocks after the last falling edge. Write and strobe counts are read only after CS_n has been high for three clocks. Status effects are read back through a later status-read selection. The bench sweeps all four protection settings against addresses on both sides of each range boundary, and every unlisted opcode value, with expectations computed arithmetically.

// File: rtl/spi_nv_pkg.sv
package spi_nv_pkg;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_WRSR   = 8'h01;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_WRITE  = 8'h02;
    localparam logic [7:0] OP_STORE  = 8'h3C;
    localparam logic [7:0] OP_RECALL = 8'h60;
    localparam logic [7:0] OP_ASEN   = 8'h59;
    localparam logic [7:0] OP_ASDIS  = 8'h19;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_RD_DATA,
        ST_WR_DATA,
        ST_RDSR,
        ST_WRSR,
        ST_DONE,
        ST_IGNORE
    } ctl_state_t;

endpackage

// File: rtl/spi_nv_phy.sv
// Edge detection, bit counting and byte shifting for an SPI mode-0 slave.
module spi_nv_phy #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sel_start,
    output logic              sel_end,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              sck_q, cs_q, active;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sr, tx_sr;
    logic              sck_rise, sck_fall;

    // cs_q resets low so a select already low at reset is not an edge (R2)
    assign sel_start = cs_q & ~cs_n;
    assign sel_end   = ~cs_q & cs_n;
    assign sck_rise  = active & ~sck_q & sck;
    assign sck_fall  = active & sck_q & ~sck;
    assign byte_done = sck_rise && (bit_cnt == CNT_W'(BYTE_W - 1));
    assign rx_byte   = {rx_sr[BYTE_W-2:0], mosi};
    assign miso      = active & tx_sr[BYTE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q   <= 1'b0;
            cs_q    <= 1'b0;
            active  <= 1'b0;
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (sel_start) begin
                active  <= 1'b1;
                bit_cnt <= '0;
                tx_sr   <= '0;
            end else if (sel_end) begin
                active <= 1'b0;
            end
            if (sck_rise) begin
                bit_cnt <= bit_cnt + 1'b1;
                rx_sr   <= rx_byte;
            end
            // a falling edge at a byte boundary presents the next byte's MSB
            if (sck_fall) begin
                if (bit_cnt == '0) tx_sr <= tx_byte;
                else               tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/spi_nv_status.sv
// Status byte: volatile WEN, nonvolatile WPEN/BP1/BP0, busy passthrough.
module spi_nv_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] nv_init,
    input  logic       wen_set,
    input  logic       wen_clr,
    input  logic       sr_wr,
    input  logic [2:0] sr_bits,
    input  logic       seq_busy,
    output logic       wen,
    output logic       wpen,
    output logic [1:0] bp,
    output logic [7:0] status
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wen  <= 1'b0;
            wpen <= nv_init[2];
            bp   <= nv_init[1:0];
        end else begin
            if (wen_clr)      wen <= 1'b0;
            else if (wen_set) wen <= 1'b1;
            if (sr_wr) begin
                wpen <= sr_bits[2];
                bp   <= sr_bits[1:0];
            end
        end
    end

    assign status = {wpen, 3'b000, bp, wen, seq_busy};

endmodule

// File: rtl/spi_nv_ctrl.sv
// Instruction state machine: decode, address phase, data streaming, guards.
module spi_nv_ctrl
    import spi_nv_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_start,
    input  logic              sel_end,
    input  logic              byte_done,
    input  logic [7:0]        rx_byte,
    input  logic              recall_active,
    input  logic              wp_n,
    input  logic              wen,
    input  logic              wpen,
    input  logic [1:0]        bp,
    input  logic [7:0]        status,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        tx_byte,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              wen_set,
    output logic              wen_clr,
    output logic              sr_wr,
    output logic [2:0]        sr_bits,
    output logic              store_req,
    output logic              recall_req,
    output logic              as_en_req,
    output logic              as_dis_req
);
    localparam int HI_W = ADDR_W - 8;

    ctl_state_t          state, nxt;
    logic [ADDR_W-1:0]   addr;
    logic [HI_W-1:0]     addr_hi;
    logic                is_wr, clr_pend;
    logic                op_ev, wr_block, prot, guarded_ok, data_ev;

    assign op_ev    = (state == ST_OPCODE) && byte_done && !recall_active;
    assign wr_block = wpen && !wp_n;
    assign data_ev  = byte_done && (state == ST_RD_DATA || state == ST_WR_DATA);

    always_comb begin
        guarded_ok = 1'b0;
        if (op_ev && wen) begin
            unique case (rx_byte)
                OP_WRITE, OP_STORE, OP_ASEN, OP_ASDIS: guarded_ok = 1'b1;
                OP_WRSR:                               guarded_ok = !wr_block;
                default:                               guarded_ok = 1'b0;
            endcase
        end
    end

    always_comb begin
        case (bp)
            2'b00:   prot = 1'b0;
            2'b01:   prot = &addr[ADDR_W-1 -: 2];
            2'b10:   prot = addr[ADDR_W-1];
            default: prot = 1'b1;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (sel_start) nxt = ST_OPCODE;
            ST_OPCODE: begin
                if (byte_done) begin
                    if (recall_active) begin
                        nxt = ST_IGNORE;
                    end else begin
                        unique case (rx_byte)
                            OP_RDSR:                       nxt = ST_RDSR;
                            OP_READ:                       nxt = ST_ADDR_HI;
                            OP_WRITE:                      nxt = wen ? ST_ADDR_HI : ST_IGNORE;
                            OP_WRSR:                       nxt = (wen && !wr_block) ? ST_WRSR : ST_IGNORE;
                            OP_WREN, OP_WRDI, OP_RECALL:   nxt = ST_DONE;
                            OP_STORE, OP_ASEN, OP_ASDIS:   nxt = wen ? ST_DONE : ST_IGNORE;
                            default:                       nxt = ST_IGNORE;
                        endcase
                    end
                end
            end
            ST_ADDR_HI: if (byte_done) nxt = ST_ADDR_LO;
            ST_ADDR_LO: if (byte_done) nxt = is_wr ? ST_WR_DATA : ST_RD_DATA;
            ST_WRSR:    if (byte_done) nxt = ST_DONE;
            ST_RD_DATA, ST_WR_DATA, ST_RDSR, ST_DONE, ST_IGNORE: nxt = state;
            default:    nxt = ST_IDLE;
        endcase
        if (sel_end) nxt = ST_IDLE;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr     <= '0;
            addr_hi  <= '0;
            is_wr    <= 1'b0;
            clr_pend <= 1'b0;
        end else begin
            if (op_ev) is_wr <= (rx_byte == OP_WRITE);
            if (state == ST_ADDR_HI && byte_done) addr_hi <= rx_byte[HI_W-1:0];
            if (state == ST_ADDR_LO && byte_done) addr <= {addr_hi, rx_byte};
            else if (data_ev)                     addr <= addr + 1'b1;
            if (sel_end)         clr_pend <= 1'b0;
            else if (guarded_ok) clr_pend <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        wen_set    = op_ev && (rx_byte == OP_WREN);
        wen_clr    = (op_ev && (rx_byte == OP_WRDI)) || (sel_end && clr_pend);
        store_req  = guarded_ok && (rx_byte == OP_STORE);
        as_en_req  = guarded_ok && (rx_byte == OP_ASEN);
        as_dis_req = guarded_ok && (rx_byte == OP_ASDIS);
        recall_req = op_ev && (rx_byte == OP_RECALL);
        sr_wr      = (state == ST_WRSR) && byte_done;
        sr_bits    = {rx_byte[7], rx_byte[3:2]};
        mem_we     = (state == ST_WR_DATA) && byte_done && !prot;
        mem_wdata  = rx_byte;
        mem_addr   = addr;
        unique case (state)
            ST_RDSR:    tx_byte = status;
            ST_RD_DATA: tx_byte = mem_rdata;
            default:    tx_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/spi_nvsram_cmd.sv
// Top: SPI command front end of a nonvolatile SRAM.
module spi_nvsram_cmd #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    input  logic              wp_n,
    input  logic              seq_busy,
    input  logic              recall_active,
    input  logic [2:0]        nv_init,
    output logic [2:0]        nv_bits,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    input  logic [7:0]        mem_rdata,
    output logic              store_req,
    output logic              recall_req,
    output logic              as_en_req,
    output logic              as_dis_req
);
    logic       sel_start, sel_end, byte_done;
    logic [7:0] rx_byte, tx_byte, st_byte;
    logic       wen_set, wen_clr, sr_wr;
    logic [2:0] sr_bits;
    logic       st_wen, st_wpen;
    logic [1:0] st_bp;

    spi_nv_phy #(.BYTE_W(8)) u_phy (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck       (sck),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .tx_byte   (tx_byte),
        .sel_start (sel_start),
        .sel_end   (sel_end),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso      (miso)
    );

    spi_nv_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .nv_init  (nv_init),
        .wen_set  (wen_set),
        .wen_clr  (wen_clr),
        .sr_wr    (sr_wr),
        .sr_bits  (sr_bits),
        .seq_busy (seq_busy),
        .wen      (st_wen),
        .wpen     (st_wpen),
        .bp       (st_bp),
        .status   (st_byte)
    );

    spi_nv_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel_start     (sel_start),
        .sel_end       (sel_end),
        .byte_done     (byte_done),
        .rx_byte       (rx_byte),
        .recall_active (recall_active),
        .wp_n          (wp_n),
        .wen           (st_wen),
        .wpen          (st_wpen),
        .bp            (st_bp),
        .status        (st_byte),
        .mem_rdata     (mem_rdata),
        .tx_byte       (tx_byte),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_we        (mem_we),
        .wen_set       (wen_set),
        .wen_clr       (wen_clr),
        .sr_wr         (sr_wr),
        .sr_bits       (sr_bits),
        .store_req     (store_req),
        .recall_req    (recall_req),
        .as_en_req     (as_en_req),
        .as_dis_req    (as_dis_req)
    );

    assign nv_bits = {st_wpen, st_bp};

endmodule

// File: rtl/spi_nvsram_cmd_chk.sv
module spi_nvsram_cmd_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              recall_active,
    input logic              wen,
    input logic [1:0]        bp,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              store_req,
    input logic              recall_req,
    input logic              as_en_req,
    input logic              as_dis_req
);
    logic in_range;
    always_comb begin
        in_range = (bp == 2'b11)
                || (bp == 2'b10 && mem_addr[ADDR_W-1])
                || (bp == 2'b01 && mem_addr[ADDR_W-1] && mem_addr[ADDR_W-2]);
    end

    // R7: an array write only happens with the latch set
    p_we_needs_wen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wen);

    // R9: no write lands in the protected range
    p_we_outside_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !in_range);

    // R11: at most one request strobe per cycle
    p_req_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_req, recall_req, as_en_req, as_dis_req}));

    // R7: guarded requests need the latch
    p_guarded_req_wen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req || as_en_req || as_dis_req) |-> wen);

    // R6: no request is issued during a restore
    p_recall_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req || recall_req || as_en_req || as_dis_req) |-> !recall_active);

    // R2: a deselected device does nothing
    p_deselected_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !(mem_we || store_req || recall_req || as_en_req || as_dis_req));

endmodule

bind spi_nvsram_cmd spi_nvsram_cmd_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_n          (cs_n),
    .recall_active (recall_active),
    .wen           (st_wen),
    .bp            (st_bp),
    .mem_addr      (mem_addr),
    .mem_we        (mem_we),
    .store_req     (store_req),
    .recall_req    (recall_req),
    .as_en_req     (as_en_req),
    .as_dis_req    (as_dis_req)
);

// File: tb/sim_spi_nvsram_cmd.sv
`timescale 1ns/1ps
module sim_spi_nvsram_cmd;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, cs_n = 1'b0, mosi = 1'b0;
    logic        wp_n = 1'b1, seq_busy = 1'b0, recall_active = 1'b0;
    logic [2:0]  nv_init = 3'b010;
    logic        miso, mem_we;
    logic [2:0]  nv_bits;
    logic [14:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        store_req, recall_req, as_en_req, as_dis_req;

    int total = 0, fails = 0;
    bit done = 0;
    int wcnt = 0, n_store = 0, n_recall = 0, n_ase = 0, n_asd = 0;
    logic [14:0] wlast_addr = '0;
    logic [7:0]  wlast_data = '0;

    always #10 clk = ~clk;

    function automatic logic [7:0] pat(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    endfunction

    assign mem_rdata = pat(mem_addr);

    spi_nvsram_cmd u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .wp_n(wp_n), .seq_busy(seq_busy), .recall_active(recall_active),
        .nv_init(nv_init), .nv_bits(nv_bits), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .store_req(store_req), .recall_req(recall_req),
        .as_en_req(as_en_req), .as_dis_req(as_dis_req)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                wcnt       <= wcnt + 1;
                wlast_addr <= mem_addr;
                wlast_data <= mem_wdata;
            end
            if (store_req)  n_store  <= n_store + 1;
            if (recall_req) n_recall <= n_recall + 1;
            if (as_en_req)  n_ase    <= n_ase + 1;
            if (as_dis_req) n_asd    <= n_asd + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk) mosi = tx[i];
            repeat (3) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic sel();
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic desel();
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        sel(); xfer(op, d); desel();
    endtask

    task automatic cmd2(input logic [7:0] op, input logic [7:0] b);
        logic [7:0] d;
        sel(); xfer(op, d); xfer(b, d); desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        sel(); xfer(8'h05, d); xfer(8'h00, s); desel();
    endtask

    function automatic logic [7:0] stat(input logic wpen, input logic [1:0] bp,
                                        input logic wen, input logic busy);
        return {wpen, 3'b000, bp, wen, busy};
    endfunction

    function automatic bit listed(input logic [7:0] op);
        return op == 8'h06 || op == 8'h04 || op == 8'h05 || op == 8'h01 || op == 8'h03 ||
               op == 8'h02 || op == 8'h3C || op == 8'h60 || op == 8'h59 || op == 8'h19;
    endfunction

    initial begin
        logic [7:0] r, r2;
        int w0, s0, rc0, a0, d0;
        logic [14:0] alist [6];
        alist[0] = 15'h0000; alist[1] = 15'h3FFF; alist[2] = 15'h4000;
        alist[3] = 15'h5FFF; alist[4] = 15'h6000; alist[5] = 15'h7FFF;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 reset miso", miso, 1'b0);

        // R2: select low since reset, no falling edge yet
        xfer(8'h06, r); xfer(8'h05, r); xfer(8'h00, r2);
        chk("R2 no response before CS fall", r2, 8'h00);
        desel();
        chk("R2 no write before CS fall", wcnt, 0);

        // R5: reset status, nonvolatile bits from nv_init
        rdsr(r);
        chk("R5 reset status", r, stat(1'b0, 2'b10, 1'b0, 1'b0));
        chk("R5 nv_bits", nv_bits, 3'b010);

        // R3/R7: WEN set and clear
        cmd1(8'h06); rdsr(r);
        chk("R3 R7 WREN", r, stat(1'b0, 2'b10, 1'b1, 1'b0));
        cmd1(8'h04); rdsr(r);
        chk("R3 R7 WRDI", r, stat(1'b0, 2'b10, 1'b0, 1'b0));

        // R12/R5: repeated status bytes, busy bit
        seq_busy = 1'b1;
        sel(); xfer(8'h05, r); xfer(8'h00, r); xfer(8'h00, r2); desel();
        chk("R12 first status byte", r, 8'h09);
        chk("R12 second status byte", r2, 8'h09);
        seq_busy = 1'b0;

        // R8/R1: read with ignored top bit and wrap
        sel(); xfer(8'h03, r); xfer(8'hFF, r); xfer(8'hFE, r);
        for (int k = 0; k < 4; k++) begin
            logic [14:0] a;
            a = 15'h7FFE + 15'(k);
            xfer(8'h00, r);
            chk("R8 R1 read data", r, pat(a));
        end
        desel();

        // R7: write refused without WEN
        w0 = wcnt;
        sel(); xfer(8'h02, r); xfer(8'h01, r); xfer(8'h00, r); xfer(8'hAA, r); xfer(8'hBB, r); desel();
        chk("R7 write without WEN", wcnt, w0);

        // R9/R8: BP=10, write from 0x7FFF wraps into 0x0000
        cmd1(8'h06);
        w0 = wcnt;
        sel(); xfer(8'h02, r); xfer(8'h7F, r); xfer(8'hFF, r);
        xfer(8'h11, r); xfer(8'h22, r); xfer(8'h33, r); desel();
        chk("R9 R8 write count", wcnt, w0 + 2);
        chk("R8 last addr", wlast_addr, 15'h0001);
        chk("R8 last data", wlast_data, 8'h33);
        rdsr(r);
        chk("R7 WEN cleared after write", r, stat(1'b0, 2'b10, 1'b0, 1'b0));

        // R9/R10: protection sweep
        for (int bp = 0; bp < 4; bp++) begin
            cmd1(8'h06);
            cmd2(8'h01, {4'b0000, 2'(bp), 2'b00});
            rdsr(r);
            chk("R10 status after write", r, stat(1'b0, 2'(bp), 1'b0, 1'b0));
            for (int j = 0; j < 6; j++) begin
                logic [14:0] a;
                bit pr;
                a  = alist[j];
                pr = (bp == 3) || (bp == 2 && a[14]) || (bp == 1 && a[14] && a[13]);
                cmd1(8'h06);
                w0 = wcnt;
                sel(); xfer(8'h02, r); xfer({1'b0, a[14:8]}, r); xfer(a[7:0], r);
                xfer(a[7:0] ^ 8'hC3, r); desel();
                chk("R9 protected write", wcnt - w0, pr ? 0 : 1);
                if (!pr) chk("R9 write addr", wlast_addr, a);
            end
        end

        // R10: WPEN with wp_n
        cmd1(8'h06); cmd2(8'h01, 8'h80); rdsr(r);
        chk("R10 WPEN set", r, 8'h80);
        chk("R10 nv_bits", nv_bits, 3'b100);
        wp_n = 1'b0;
        cmd1(8'h06); cmd2(8'h01, 8'h0C); rdsr(r);
        chk("R10 blocked status write", r, 8'h82);
        cmd1(8'h04);
        wp_n = 1'b1;
        cmd1(8'h06); cmd2(8'h01, 8'h00); rdsr(r);
        chk("R10 unblocked status write", r, 8'h00);

        // R11/R7: request strobes
        s0 = n_store; rc0 = n_recall; a0 = n_ase; d0 = n_asd;
        cmd1(8'h06); cmd1(8'h3C);
        chk("R11 store strobe", n_store, s0 + 1);
        rdsr(r);
        chk("R7 WEN cleared after store", r, 8'h00);
        cmd1(8'h59);
        chk("R7 autosave enable refused", n_ase, a0);
        cmd1(8'h06); cmd1(8'h59);
        chk("R11 autosave enable strobe", n_ase, a0 + 1);
        cmd1(8'h06); cmd1(8'h19);
        chk("R11 autosave disable strobe", n_asd, d0 + 1);
        cmd1(8'h60);
        chk("R11 recall strobe without WEN", n_recall, rc0 + 1);

        // R6: restore in progress
        recall_active = 1'b1;
        cmd1(8'h06);
        cmd1(8'h60);
        sel(); xfer(8'h05, r); xfer(8'h00, r2); desel();
        recall_active = 1'b0;
        chk("R6 status read refused", r2, 8'h00);
        chk("R6 recall refused", n_recall, rc0 + 1);
        rdsr(r);
        chk("R6 WREN refused", r, 8'h00);

        // R4: every unlisted opcode, with WEN set
        cmd1(8'h06);
        w0 = wcnt; s0 = n_store; rc0 = n_recall; a0 = n_ase; d0 = n_asd;
        for (int op = 0; op < 256; op++) begin
            if (!listed(8'(op))) begin
                sel(); xfer(8'(op), r); xfer(8'h00, r2); desel();
                chk("R4 unlisted opcode miso", r2, 8'h00);
                rdsr(r);
                chk("R4 unlisted opcode status", r, 8'h02);
            end
        end
        chk("R4 no writes", wcnt, w0);
        chk("R4 no strobes", n_store + n_recall + n_ase + n_asd, s0 + rc0 + a0 + d0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule